// File: doc/BRIEF.md
# Bus Hold and Halt Arbiter

This block decides, cycle by cycle, whether a small processor core keeps its bus, hands it to an external DMA master, or parks in a halted state. It also decides when a pending unmasked interrupt is taken. It sits next to the core's T-state sequencer, and each clock cycle is one T-state. The sequencer tells the arbiter, through two strobes, which T-states during normal execution are legal sampling points for the DMA request and for the interrupt lines. While halted or holding, the arbiter samples both in every cycle.

A DMA request always beats an interrupt that is seen in the same cycle. The interrupt is not lost: it stays captured and is taken once the bus returns. Only one interrupt is held at a time. The first one seen is kept, and any that arrive later are dropped until it has been accepted. An interrupt is accepted as a single-cycle one-hot pulse. When that acceptance wakes the core from halt, it comes with a resume-fetch pulse.

Top module: `bus_yield_arbiter`

## Requirements
- R1: While `rst` is high and on the first cycles after it, `hold_ack`, `bus_float`, `irq_accept` and `resume_fetch` are all zero, the arbiter is executing, and no interrupt is captured.
- R2: When halted, a high `hold_req` in cycle n raises `hold_ack` in cycle n+2, even if an interrupt line is also high in cycle n. That interrupt produces no accept while the bus is held, and is accepted once the arbiter is halted again.
- R3: `hold_ack` and `bus_float` are both high in every cycle the arbiter holds the bus and in no other cycle, and `irq_accept` is zero in those cycles.
- R4: While holding, a low `hold_req` in cycle n drops `hold_ack` and `bus_float` in cycle n+2, and the arbiter goes to the halted state.
- R5: While executing, `hold_req` has effect only through a cycle in which `smp_hold_stb` is high. If `hold_req` is high in that cycle n and also in cycle n+1, `hold_ack` rises in cycle n+3. If it is low in cycle n+1, no hold follows.
- R6: When halted with `hold_req` low, an interrupt seen in cycle n produces a one-hot `irq_accept` together with `resume_fetch` in cycle n+2, each for exactly one cycle. The arbiter then executes.
- R7: While holding, only the first interrupt line seen is captured, and lines raised later are ignored whatever their index. The captured line is the one accepted after the hold ends.
- R8: If several interrupt lines are first seen in the same cycle, the lowest-numbered one is captured. Bit i of `irq_accept` corresponds to bit i of `irq_req`.
- R9: While executing, `irq_req` is sampled only in cycles with `smp_irq_stb` high. An interrupt seen in such a cycle n gives `irq_accept` in cycle n+2 with `resume_fetch` low.
- R10: While executing with no hold pending, a high `halt_stb` for one cycle moves the arbiter into the halted state. After that, `hold_req` is sampled every cycle without any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle per T-state |
| rst | input | 1 | Synchronous active-high reset |
| hold_req | input | 1 | Bus request from the DMA master |
| irq_req | input | N_IRQ | Unmasked, enabled interrupt requests |
| halt_stb | input | 1 | Core executed a halt instruction |
| smp_hold_stb | input | 1 | Sequencer marks a T-state where the bus request may be sampled |
| smp_irq_stb | input | 1 | Sequencer marks the T-state where interrupts may be sampled |
| hold_ack | output | 1 | Bus granted to the DMA master |
| bus_float | output | 1 | Float the core's bus drivers |
| irq_accept | output | N_IRQ | One-cycle one-hot accept of the captured interrupt |
| resume_fetch | output | 1 | One-cycle pulse: leave halt and start an opcode fetch |

## Verification
The assertions take for granted that the sequencer never raises both sampling strobes and `halt_stb` as a tangle of overlapping pulses. Each strobe is a single-cycle pulse at an isolated T-state, and `halt_stb` comes only while the core is executing. The directed stimulus keeps to this by raising every strobe for exactly one cycle, with idle cycles between them. It changes `hold_req` and `irq_req` only right after a clock edge, so each sampled value is unambiguous.

// File: rtl/bya_pkg.sv
package bya_pkg;

    typedef enum logic [1:0] {
        ST_EXEC = 2'd0,
        ST_HALT = 2'd1,
        ST_HOLD = 2'd2
    } arb_state_e;

    // Halted and holding states sample their inputs in every T-state.
    function automatic logic samples_each_cycle(input arb_state_e s);
        return (s == ST_HALT) || (s == ST_HOLD);
    endfunction

endpackage

// File: rtl/bya_hold_sampler.sv
module bya_hold_sampler
    import bya_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  arb_state_e state,
    input  logic       hold_req,
    input  logic       smp_hold_stb,
    output logic       hold_lat,
    output logic       hold_arm
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_lat <= 1'b0;
            hold_arm <= 1'b0;
        end else if (samples_each_cycle(state)) begin
            hold_lat <= hold_req;
            hold_arm <= 1'b0;
        end else if (hold_arm) begin
            // Bus is handed over on this edge; hold state starts latched high.
            hold_lat <= 1'b1;
            hold_arm <= 1'b0;
        end else if (smp_hold_stb) begin
            hold_lat <= hold_req;
        end else if (hold_lat) begin
            // Confirmation cycle: request must still be present.
            hold_arm <= hold_req;
            hold_lat <= 1'b0;
        end
    end

    // R5: outside the marked T-states an executing core never newly latches the request
    a_r5_sample_points: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && !smp_hold_stb && !hold_arm) |=> !hold_lat);

endmodule

// File: rtl/bya_irq_capture.sv
module bya_irq_capture #(
    parameter int N_IRQ = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_en,
    input  logic             clear,
    input  logic [N_IRQ-1:0] irq_req,
    output logic             cap_valid,
    output logic [N_IRQ-1:0] cap_onehot
);

    localparam logic [N_IRQ-1:0] ONE_LSB = N_IRQ'(1);

    logic [N_IRQ-1:0] lowest;
    assign lowest = irq_req & (~irq_req + ONE_LSB);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cap_valid  <= 1'b0;
            cap_onehot <= '0;
        end else if (sample_en && !cap_valid && (|irq_req)) begin
            cap_valid  <= 1'b1;
            cap_onehot <= lowest;
        end
    end

    // R7: a held capture is never replaced before it is serviced
    a_r7_first_kept: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && !clear) |=> (cap_valid && $stable(cap_onehot)));

    // R8: request line 0 beats every other line seen with it
    a_r8_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        (sample_en && !clear && !cap_valid && irq_req[0]) |=> cap_onehot[0]);

    // R8: the capture is always a single line
    a_r8_single_line: assert property (@(posedge clk) disable iff (rst)
        cap_valid |-> ($countones(cap_onehot) == 1));

endmodule

// File: rtl/bus_yield_arbiter.sv
module bus_yield_arbiter
    import bya_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_req,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             halt_stb,
    input  logic             smp_hold_stb,
    input  logic             smp_irq_stb,
    output logic             hold_ack,
    output logic             bus_float,
    output logic [N_IRQ-1:0] irq_accept,
    output logic             resume_fetch
);

    arb_state_e       state_q, state_d;
    logic             hold_lat, hold_arm, hold_pending;
    logic             cap_valid, irq_sample_en;
    logic [N_IRQ-1:0] cap_onehot;
    logic             svc_halt, svc_exec, svc;
    logic [N_IRQ-1:0] accept_q;
    logic             resume_q;

    bya_hold_sampler u_hold (
        .clk          (clk),
        .rst          (rst),
        .state        (state_q),
        .hold_req     (hold_req),
        .smp_hold_stb (smp_hold_stb),
        .hold_lat     (hold_lat),
        .hold_arm     (hold_arm)
    );

    assign irq_sample_en = samples_each_cycle(state_q) ||
                           (state_q == ST_EXEC && smp_irq_stb);

    bya_irq_capture #(.N_IRQ(N_IRQ)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .sample_en  (irq_sample_en),
        .clear      (svc),
        .irq_req    (irq_req),
        .cap_valid  (cap_valid),
        .cap_onehot (cap_onehot)
    );

    assign hold_pending = hold_lat || hold_arm;
    assign svc_halt = (state_q == ST_HALT) && !hold_lat && cap_valid;
    assign svc_exec = (state_q == ST_EXEC) && !hold_pending && !halt_stb && cap_valid;
    assign svc      = svc_halt || svc_exec;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EXEC: begin
                if (hold_arm)                        state_d = ST_HOLD;
                else if (halt_stb && !hold_pending)  state_d = ST_HALT;
            end
            ST_HALT: begin
                if (hold_lat)       state_d = ST_HOLD;
                else if (cap_valid) state_d = ST_EXEC;
            end
            ST_HOLD: begin
                if (!hold_lat)      state_d = ST_HALT;
            end
            default: state_d = ST_EXEC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_EXEC;
            accept_q <= '0;
            resume_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            accept_q <= svc ? cap_onehot : '0;
            resume_q <= svc_halt;
        end
    end

    assign hold_ack     = (state_q == ST_HOLD);
    assign bus_float    = (state_q == ST_HOLD);
    assign irq_accept   = accept_q;
    assign resume_fetch = resume_q;

    // R2: a latched request while halted hands over the bus on the next edge
    a_r2_halt_yields: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT && hold_lat) |=> hold_ack);

    // R4: a latched low request while holding gives the bus back
    a_r4_hold_release: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && !hold_lat) |=> (!hold_ack && state_q == ST_HALT));

    // R3: no interrupt is accepted while the bus is held
    a_r3_no_accept_in_hold: assert property (@(posedge clk) disable iff (rst)
        hold_ack |-> (irq_accept == '0));

    // R6: accept is one-hot or idle
    a_r6_accept_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_accept));

    // R6: resuming from halt always carries an accepted interrupt
    a_r6_resume_has_accept: assert property (@(posedge clk) disable iff (rst)
        resume_fetch |-> (irq_accept != '0));

    // R10: halt strobe with nothing pending parks the core
    a_r10_halt_entry: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && halt_stb && !hold_pending) |=> (state_q == ST_HALT));

endmodule

// File: tb/bus_yield_arbiter_tb.sv
module bus_yield_arbiter_tb;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         hold_req = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic         halt_stb = 1'b0;
    logic         smp_hold_stb = 1'b0;
    logic         smp_irq_stb = 1'b0;
    logic         hold_ack, bus_float, resume_fetch;
    logic [N-1:0] irq_accept;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_yield_arbiter #(.N_IRQ(N)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .hold_req     (hold_req),
        .irq_req      (irq_req),
        .halt_stb     (halt_stb),
        .smp_hold_stb (smp_hold_stb),
        .smp_irq_stb  (smp_irq_stb),
        .hold_ack     (hold_ack),
        .bus_float    (bus_float),
        .irq_accept   (irq_accept),
        .resume_fetch (resume_fetch)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; hold_req = 1'b0; irq_req = '0;
        halt_stb = 1'b0; smp_hold_stb = 1'b0; smp_irq_stb = 1'b0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic go_halt();
        halt_stb = 1'b1;
        step();
        halt_stb = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        chk("R1 hold_ack in reset", 32'(hold_ack), 0);
        chk("R1 bus_float in reset", 32'(bus_float), 0);
        chk("R1 accept in reset", 32'(irq_accept), 0);
        rst = 1'b0;
        step();
        chk("R1 resume after reset", 32'(resume_fetch), 0);
        go_halt();
        step(); step();
        chk("R1 no stale capture", 32'(irq_accept), 0);
        chk("R1 no stale resume", 32'(resume_fetch), 0);
    endtask

    task automatic t_exec_hold();
        do_reset();
        hold_req = 1'b1;
        for (int i = 0; i < 5; i++) step();
        chk("R5 request ignored without strobe", 32'(hold_ack), 0);
        smp_hold_stb = 1'b1;
        step();
        smp_hold_stb = 1'b0;
        chk("R5 not yet held n+1", 32'(hold_ack), 0);
        step();
        chk("R5 not yet held n+2", 32'(hold_ack), 0);
        step();
        chk("R5 held at n+3", 32'(hold_ack), 1);
        chk("R3 float while held", 32'(bus_float), 1);
        step(); step();
        chk("R3 still held", 32'(hold_ack & bus_float), 1);
        hold_req = 1'b0;
        step();
        chk("R4 held one more cycle", 32'(hold_ack), 1);
        step();
        chk("R4 released hold_ack", 32'(hold_ack), 0);
        chk("R4 released bus_float", 32'(bus_float), 0);
        // R4: now halted, so an interrupt is taken with resume
        irq_req = 4'b0100;
        step();
        irq_req = '0;
        step();
        chk("R4 halted after hold", 32'(resume_fetch), 1);
        // R5 glitch: request gone in the confirmation cycle
        do_reset();
        hold_req = 1'b1; smp_hold_stb = 1'b1;
        step();
        hold_req = 1'b0; smp_hold_stb = 1'b0;
        step(); step(); step();
        chk("R5 unconfirmed request dropped", 32'(hold_ack), 0);
    endtask

    task automatic t_halt_hold_irq();
        do_reset();
        go_halt();
        hold_req = 1'b1;
        irq_req = 4'b0100;
        step();
        irq_req = '0;
        chk("R2 not held at n+1", 32'(hold_ack), 0);
        step();
        chk("R10 R2 held at n+2 without strobe", 32'(hold_ack), 1);
        chk("R2 no accept while held", 32'(irq_accept), 0);
        step();
        chk("R3 no accept in hold", 32'(irq_accept), 0);
        hold_req = 1'b0;
        step(); step();
        chk("R4 hold dropped", 32'(hold_ack), 0);
        step();
        chk("R2 kept interrupt accepted", 32'(irq_accept), 32'h4);
        chk("R2 resume with accept", 32'(resume_fetch), 1);
        step();
        chk("R6 accept lasts one cycle", 32'(irq_accept), 0);
        chk("R6 resume lasts one cycle", 32'(resume_fetch), 0);
    endtask

    task automatic t_halt_irq();
        do_reset();
        go_halt();
        irq_req = 4'b0110;
        step();
        irq_req = '0;
        chk("R6 no accept at n+1", 32'(irq_accept), 0);
        step();
        chk("R8 lowest line accepted", 32'(irq_accept), 32'h2);
        chk("R6 resume pulse", 32'(resume_fetch), 1);
        step();
        chk("R6 accept cleared", 32'(irq_accept), 0);
        hold_req = 1'b1;
        step(); step(); step();
        chk("R6 executing after resume", 32'(hold_ack), 0);
    endtask

    task automatic t_hold_first_irq();
        do_reset();
        go_halt();
        hold_req = 1'b1;
        step(); step();
        chk("R7 entered hold", 32'(hold_ack), 1);
        irq_req = 4'b1000;
        step();
        irq_req = 4'b0001;
        step(); step();
        irq_req = '0;
        hold_req = 1'b0;
        step(); step();
        chk("R7 hold over", 32'(hold_ack), 0);
        step();
        chk("R7 first interrupt kept", 32'(irq_accept), 32'h8);
        step();
        step();
        chk("R7 later line discarded", 32'(irq_accept), 0);
    endtask

    task automatic t_exec_irq();
        do_reset();
        irq_req = 4'b0100;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R9 no accept without strobe", 32'(irq_accept), 0);
        end
        smp_irq_stb = 1'b1;
        step();
        smp_irq_stb = 1'b0;
        irq_req = '0;
        chk("R9 no accept at n+1", 32'(irq_accept), 0);
        step();
        chk("R9 accept at n+2", 32'(irq_accept), 32'h4);
        chk("R9 no resume while executing", 32'(resume_fetch), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_exec_hold();
        t_halt_hold_irq();
        t_halt_irq();
        t_hold_first_irq();
        t_exec_irq();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule